// File: doc/BRIEF.md
# Frame Sync and Reset Pulse Generator

This block drives the outgoing synchronization line that tells an upstream data source where its frames have to sit in time. In frame mode the line carries a continuous square wave at the frame rate (8 kHz from a 155.52 MHz clock), high for exactly half of each period. Its rising edge marks where each frame begins. In reset mode the line rests at an idle level. A reset request then produces a single pulse of fixed width (about 400 ns), which restarts the upstream transmit flow. The active level of that pulse is programmable.

The reset request arrives asynchronously and is retimed by a two-flop synchronizer. Its rising edge starts the pulse. The same event also opens a clock-squelch window of about 800 ns, which the clock-output stage uses to gate the drop-side clock. That window is never opened while the interface runs at the high line rate. A request that arrives while a pulse or a squelch window is still open is dropped. A change of mode restarts the frame timing from the beginning of a frame. The block has no data stream, so every pin is a plain level-type control or status signal.

Top module: `frame_sync_gen`

## Requirements
- R1: While `rst_n` is low, `sync_out` and `squelch_en` are both 0.
- R2: In frame mode (`mode_sel`=0) `sync_out` is periodic with period 2*HALF_CYC clocks: high for HALF_CYC consecutive clocks, then low for HALF_CYC.
- R3: The rising edge of `sync_out` marks frame start. When reset is released in frame mode, `sync_out` is 1 from the first clock edge onward, and that clock is the first of a high half.
- R4: In reset mode (`mode_sel`=1), a rising edge of `req_async` first sampled at clock edge k makes `sync_out` active from edge k+2 for exactly PULSE_CYC clocks.
- R5: `rst_pol`=1 makes the reset-mode pulse active high with idle level 0. `rst_pol`=0 makes it active low with idle level 1.
- R6: With `hi_rate`=0, each accepted request drives `squelch_en` to 1 from the same edge as the pulse, for exactly SQUELCH_CYC clocks.
- R7: With `hi_rate`=1, an accepted request still produces the pulse, but `squelch_en` stays 0.
- R8: A request rising edge that arrives while the pulse or the squelch window is active is ignored: neither window is extended or restarted.
- R9: A change of `mode_sel` drives `sync_out` to the inactive level of the new mode (0 in frame mode, the idle level of R5 in reset mode) for one clock. Frame timing then restarts at the start of a high half.
- R10: In frame mode, reset requests have no effect: `squelch_en` stays 0 and the square wave of R2 continues undisturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (155.52 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 1 | 0 = frame square-wave mode, 1 = reset-pulse mode |
| rst_pol | input | 1 | Active level of the reset pulse (1 = high) |
| hi_rate | input | 1 | 1 = high-rate interface, suppresses clock squelch |
| req_async | input | 1 | Asynchronous reset request; its rising edge starts a pulse |
| sync_out | output | 1 | Outgoing synchronization line |
| squelch_en | output | 1 | Gate enable for the drop-side clock output |

## Verification
The square wave is observed over several whole periods, both straight out of reset and after a mid-period return from reset mode. This separates a correct restart of the frame phase from a counter that merely keeps running, and it also exposes off-by-one errors in the half length. Reset pulses are fired with randomized polarity, rate setting and request hold time. Measuring the start cycle and the width of both the pulse and the squelch window separates synchronizer latency errors from window-length errors. Some trials re-raise the request inside an open window, which catches a design that re-arms or stretches it. A request injected in frame mode shows whether squelch or pulse logic leaks into the wrong mode.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  typedef enum logic {
    SYNC_FRAME = 1'b0,
    SYNC_RESET = 1'b1
  } sync_mode_e;
endpackage

// File: rtl/fsg_sync.sv
// Multi-flop synchronizer with rising-edge detection on the retimed signal.
module fsg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic rise
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;
  logic          prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[LAST-1:0], d_async};
      prev  <= chain[LAST];
    end
  end

  assign rise = chain[LAST] & ~prev;

  // R4: an edge is reported for a single cycle only
  p_rise_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/fsg_window.sv
// Fixed-length countdown window; a start while open is rejected upstream.
module fsg_window #(
  parameter int LEN = 62
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic start,
  output logic active
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LEN_V = CW'(LEN);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= '0;
    else if (clr)       cnt <= '0;
    else if (start)     cnt <= LEN_V;
    else if (cnt != 0)  cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);

  // R8: no reload while the window is open
  p_no_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> !start);
  // R8: an open window only shrinks until cleared
  p_no_extend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> (cnt < $past(cnt)));
  p_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LEN_V);
endmodule

// File: rtl/fsg_frame_timer.sv
// Frame-rate square wave: high for HALF clocks then low for HALF clocks.
module fsg_frame_timer #(
  parameter int HALF = 9720
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic level
);
  localparam int PER = 2 * HALF;
  localparam int PW  = $clog2(PER);
  localparam logic [PW-1:0] LAST_V = PW'(PER - 1);
  localparam logic [PW-1:0] HALF_V = PW'(HALF);

  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (!rst_n || hold) begin
      phase <= '0;
      level <= 1'b0;
    end else begin
      level <= (phase < HALF_V);
      phase <= (phase == LAST_V) ? '0 : phase + 1'b1;
    end
  end

  // R3: a high half starts only at frame phase zero
  p_rise_at_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(level) |-> (phase == PW'(1)));
  // R2: the phase counter stays within one frame period
  p_phase_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= LAST_V);
endmodule

// File: rtl/frame_sync_gen.sv
module frame_sync_gen
  import fsg_pkg::*;
#(
  parameter int HALF_CYC    = 9720,
  parameter int PULSE_CYC   = 62,
  parameter int SQUELCH_CYC = 124,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_sel,
  input  logic rst_pol,
  input  logic hi_rate,
  input  logic req_async,
  output logic sync_out,
  output logic squelch_en
);
  sync_mode_e mode_q;
  sync_mode_e mode_in;
  logic       mode_chg;
  logic       req_rise;
  logic       frame_hi;
  logic       pulse_on;
  logic       sq_on;
  logic       busy;
  logic       start;

  assign mode_in  = sync_mode_e'(mode_sel);
  assign mode_chg = (mode_in != mode_q);

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= SYNC_FRAME;
    else        mode_q <= mode_in;
  end

  fsg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(req_async), .rise(req_rise)
  );

  fsg_frame_timer #(.HALF(HALF_CYC)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .hold(mode_chg || (mode_q != SYNC_FRAME)),
    .level(frame_hi)
  );

  assign busy  = pulse_on | sq_on;
  assign start = req_rise && !busy && !mode_chg && (mode_q == SYNC_RESET);

  fsg_window #(.LEN(PULSE_CYC)) u_pulse (
    .clk(clk), .rst_n(rst_n), .clr(mode_chg), .start(start), .active(pulse_on)
  );

  fsg_window #(.LEN(SQUELCH_CYC)) u_squelch (
    .clk(clk), .rst_n(rst_n), .clr(mode_chg), .start(start && !hi_rate),
    .active(sq_on)
  );

  assign sync_out   = (mode_q == SYNC_FRAME) ? frame_hi
                                             : (pulse_on ? rst_pol : ~rst_pol);
  assign squelch_en = sq_on;

  // R7: squelch never opens on a request taken at high rate
  p_no_squelch_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(squelch_en) |-> !$past(hi_rate));
  // R9: entering frame mode holds the line low for one clock
  p_mode_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_chg && mode_in == SYNC_FRAME) |=> !sync_out);
  // R10: no squelch while in frame mode
  p_frame_no_squelch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == SYNC_FRAME) |-> !squelch_en);
  // R6: squelch opens together with the pulse
  p_squelch_with_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(squelch_en) |-> $rose(pulse_on));
  // R1: outputs idle in reset
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (!squelch_en && !sync_out));
endmodule

// File: tb/test_frame_sync_gen.sv
module test_frame_sync_gen;
  localparam int HALF = 40;
  localparam int PER  = 2 * HALF;
  localparam int PUL  = 8;
  localparam int SQ   = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_sel = 1'b0;
  logic rst_pol = 1'b1;
  logic hi_rate = 1'b0;
  logic req_async = 1'b0;
  logic sync_out;
  logic squelch_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  frame_sync_gen #(
    .HALF_CYC(HALF), .PULSE_CYC(PUL), .SQUELCH_CYC(SQ), .SYNC_STAGES(2)
  ) i_frame_sync_gen (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .rst_pol(rst_pol),
    .hi_rate(hi_rate), .req_async(req_async),
    .sync_out(sync_out), .squelch_en(squelch_en)
  );

  function automatic logic exp_frame(int j);
    return ((j % PER) < HALF);
  endfunction

  function automatic int exp_sq_len(logic hi);
    return hi ? 0 : SQ;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Samples n clocks of frame mode from sample index 0 (first high half).
  task automatic frame_loop(int n, int req_at, string tag);
    int bad = 0;
    int sqb = 0;
    int first_bad = -1;
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      if (sync_out !== exp_frame(j)) begin
        bad++;
        if (first_bad < 0) first_bad = j;
      end
      if (squelch_en !== 1'b0) sqb++;
      if (j == req_at) req_async = 1'b1;
      if (j == req_at + 3) req_async = 1'b0;
    end
    chk({tag, " mismatching samples"}, bad, 0);
    if (first_bad >= 0) $display("  first mismatch at sample %0d", first_bad);
    if (req_at >= 0) chk("R10 squelch samples in frame mode", sqb, 0);
  endtask

  // One reset-mode request; measures pulse and squelch position and width.
  task automatic pulse_trial(logic pol, logic hi, int hold, int retrig, string tag);
    int p_first = -1, p_last = -1, p_cnt = 0;
    int s_first = -1, s_cnt = 0;
    @(negedge clk);
    rst_pol = pol;
    hi_rate = hi;
    @(negedge clk);
    chk({tag, " R5 idle level"}, sync_out, !pol);
    req_async = 1'b1;
    for (int i = 1; i <= 3 + SQ + 8; i++) begin
      @(negedge clk);
      if (sync_out === pol) begin
        if (p_first < 0) p_first = i;
        p_last = i;
        p_cnt++;
      end
      if (squelch_en === 1'b1) begin
        if (s_first < 0) s_first = i;
        s_cnt++;
      end
      if (i == hold) req_async = 1'b0;
      if (retrig > 0 && i == retrig) req_async = 1'b1;
      if (retrig > 0 && i == retrig + 1) req_async = 1'b0;
    end
    req_async = 1'b0;
    chk({tag, " R4 pulse start sample"}, p_first, 3);
    chk({tag, " R4 pulse width"}, p_cnt, PUL);
    chk({tag, " R8 pulse contiguous/not extended"}, p_last - p_first + 1, PUL);
    chk({tag, hi ? " R7 squelch width" : " R6 squelch width"}, s_cnt, exp_sq_len(hi));
    if (!hi) chk({tag, " R6 squelch start sample"}, s_first, 3);
  endtask

  initial begin
    int pol, hi, hold, rt;
    void'($urandom(32'd20240611));
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 sync_out in reset", sync_out, 0);
    chk("R1 squelch_en in reset", squelch_en, 0);
    rst_n = 1'b1;
    // R3, R2: frame timing straight out of reset
    frame_loop(3 * PER, -1, "R2 R3 frame after reset");

    // enter reset mode: one inactive clock, idle level ~pol (R9)
    rst_pol = 1'b1;
    mode_sel = 1'b1;
    @(negedge clk);
    chk("R9 inactive after entering reset mode", sync_out, 0);
    chk("R9 squelch idle after mode change", squelch_en, 0);
    repeat (4) @(negedge clk);

    // directed pulses
    pulse_trial(1'b1, 1'b0, 2, 0, "dir high-pol");
    pulse_trial(1'b0, 1'b0, 1, 0, "dir low-pol");
    pulse_trial(1'b1, 1'b1, 3, 0, "dir hi-rate");
    pulse_trial(1'b0, 1'b0, 1, 5, "dir retrig R8");
    pulse_trial(1'b1, 1'b1, 2, 5, "dir retrig hi-rate R8");
    // request held high across the whole window: no second pulse
    pulse_trial(1'b1, 1'b0, 40, 0, "dir long hold R8");

    // random trials
    for (int t = 0; t < 24; t++) begin
      pol  = $urandom % 2;
      hi   = $urandom % 2;
      hold = 1 + ($urandom % 3);
      rt   = ($urandom % 2) ? 5 : 0;
      pulse_trial(pol[0], hi[0], hold, rt, $sformatf("rnd%0d", t));
      repeat ($urandom % 5) @(negedge clk);
    end

    // back to frame mode mid-window: restart from phase 0 (R9)
    rst_pol = 1'b0;
    hi_rate = 1'b0;
    req_async = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 pulse active before mode switch (low pol)", sync_out, 0);
    req_async = 1'b0;
    mode_sel = 1'b0;
    @(negedge clk);
    chk("R9 inactive clock entering frame mode", sync_out, 0);
    chk("R9 squelch cleared on mode change", squelch_en, 0);
    // R10: request during frame mode is ignored
    frame_loop(2 * PER + 10, 17, "R9 R10 frame restart");

    // short excursion into reset mode mid-period and back
    mode_sel = 1'b1;
    repeat (7) @(negedge clk);
    mode_sel = 1'b0;
    @(negedge clk);
    chk("R9 inactive after quick mode return", sync_out, 0);
    frame_loop(PER + 5, -1, "R2 frame after quick return");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule